// File: doc/BRIEF.md
# Serial Peripheral Master with Bit-Serial CRC Check

This block is a controller-side serial peripheral shift engine. It drives SCK and MOSI and samples MISO. Beside it sit two bit-serial CRC accumulators. One follows the transmitted stream and the other follows the received stream. Software loads one frame at a time into a single-entry transmit buffer and reads each completed frame from a receive word. It chooses the frame length (8 or 16 bits), the idle clock level, the sampling edge and the CRC polynomial.

When the last data frame has been handed over, software raises a request to append the checksum. The engine sends the accumulated transmit CRC as one extra frame. During that frame the MISO word is captured and compared with the receive CRC. Both accumulators hold still for the whole CRC frame. A mismatch sets a sticky error flag, which can drive an interrupt line.

Top module: `spi_crc_master`

## Requirements
- R1: Synchronous reset leaves busy, rx_valid, crc_err, crc_next and err_irq low, tx_empty high, and sck at the cfg_cpol level.
- R2: A frame carries 8 bits (cfg_wide=0) or 16 bits (cfg_wide=1), most significant bit first. It produces exactly two SCK transitions per bit, with HALF_CYC clocks between transitions. While idle, SCK rests at cfg_cpol.
- R3: MISO is sampled on the first transition of each bit when cfg_cpha=0 and on the second when cfg_cpha=1. Each completed frame appears on rx_data, right-aligned, with a one-cycle rx_valid pulse.
- R4: Each CRC register is updated once per sampled bit, MSB first. The feedback is the register MSB XOR the line bit, and crc_poly is XORed into the left-shifted value when the feedback is 1. The width is 8 bits for 8-bit frames, using crc_poly[7:0], and 16 bits for 16-bit frames. The transmit CRC is fed from MOSI and the receive CRC from MISO. The CRC frame carries the transmit CRC MSB first.
- R5: A rising edge on crc_en clears both CRC registers. The registers update only while crc_en is high.
- R6: If a data frame is waiting in the transmit buffer when the CRC is requested, that frame is sent first and the CRC frame follows it.
- R7: Neither CRC register changes during the CRC frame. A second CRC request with no data in between sends the same value.
- R8: At the end of the CRC frame, a received word that differs from the receive CRC sets crc_err. crc_err stays set until a crc_err_clr strobe, and setting wins over clearing in the same cycle. A matching word leaves it unchanged.
- R9: crc_next rises one cycle after a crc_next_set strobe and clears by itself when the CRC frame ends.
- R10: err_irq is high exactly while crc_err and err_ie are both high.
- R11: busy rises with the first frame, stays high across back-to-back frames (data or CRC), and falls once after the last one ends.
- R12: tx_wr loads the buffer and drops tx_empty only when the buffer is empty. A write while it is full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of SCK |
| cfg_cpha | input | 1 | 0: sample on first transition of a bit, 1: on second |
| cfg_wide | input | 1 | 0: 8-bit frames and CRC, 1: 16-bit |
| crc_poly | input | 16 | CRC polynomial (low 8 bits used in 8-bit mode) |
| crc_en | input | 1 | CRC accumulation enable; rising edge clears both CRCs |
| err_ie | input | 1 | Error interrupt enable |
| tx_data | input | 16 | Frame to send (right-aligned) |
| tx_wr | input | 1 | Write strobe into the one-frame buffer |
| tx_empty | output | 1 | Transmit buffer can take a frame |
| crc_next_set | input | 1 | Strobe requesting the CRC frame after pending data |
| crc_next | output | 1 | CRC frame request pending or in progress |
| rx_data | output | 16 | Last received frame (right-aligned) |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| crc_err_clr | input | 1 | Strobe clearing crc_err |
| err_irq | output | 1 | Error interrupt |
| busy | output | 1 | A frame is on the wire |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check several rules on every cycle. crc_err is sticky, crc_next only falls at the end of a frame, and rx_valid only occurs while a frame is running. SCK rests at the configured idle level when the line is quiet. Both CRC registers stay frozen while the checksum frame is on the wire. Only the bench scenarios can show the remaining behaviour: MOSI looped back to MISO in all four clock modes at both frame lengths, the expected CRC arriving as the checksum frame, data-before-CRC ordering, the clear on enable, a repeated CRC request, a corrupted checksum raising the flag and the interrupt, and the write-while-full case.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int FRAME_W  = 16;
  localparam int NARROW_W = 8;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_t;

  // place a frame so that its first bit sits in the top position
  function automatic logic [FRAME_W-1:0] left_just(input logic [FRAME_W-1:0] w,
                                                   input logic wide);
    return wide ? w : {w[NARROW_W-1:0], {(FRAME_W-NARROW_W){1'b0}}};
  endfunction
endpackage

// File: rtl/spi_crc_tick.sv
module spi_crc_tick #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else               cnt <= cnt + CW'(1);
  end

  assign tick = run && (cnt == TOP);
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         wide,
  input  logic         din,
  input  logic [W-1:0] poly,
  output logic [W-1:0] crc_q,
  output logic [W-1:0] crc_d
);
  logic         fb;
  logic [W-1:0] stepped;
  logic [W-1:0] fitted;

  always_comb begin
    fb      = (wide ? crc_q[W-1] : crc_q[NW-1]) ^ din;
    stepped = {crc_q[W-2:0], 1'b0} ^ (fb ? poly : '0);
    fitted  = wide ? stepped : {{(W-NW){1'b0}}, stepped[NW-1:0]};
    if (clr)     crc_d = '0;
    else if (en) crc_d = fitted;
    else         crc_d = crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '0;
    else     crc_q <= crc_d;
  end
endmodule

// File: rtl/spi_crc_master.sv
module spi_crc_master #(
  parameter int HALF_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_cpol,
  input  logic        cfg_cpha,
  input  logic        cfg_wide,
  input  logic [15:0] crc_poly,
  input  logic        crc_en,
  input  logic        err_ie,
  input  logic [15:0] tx_data,
  input  logic        tx_wr,
  output logic        tx_empty,
  input  logic        crc_next_set,
  output logic        crc_next,
  output logic [15:0] rx_data,
  output logic        rx_valid,
  output logic        crc_err,
  input  logic        crc_err_clr,
  output logic        err_irq,
  output logic        busy,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  import spi_crc_pkg::*;

  localparam int W  = FRAME_W;
  localparam int NW = NARROW_W;
  localparam int BW = $clog2(W);

  seq_t          state;
  logic          half_q;
  logic [BW-1:0] bit_idx;
  logic [W-1:0]  tx_sh, rx_sh, rx_nxt, tx_buf;
  logic          tx_full, crc_frame, crc_next_q, crc_err_q, crc_en_q;
  logic [W-1:0]  rx_data_q;
  logic          rx_valid_q, busy_q, sck_q;
  logic [W-1:0]  tx_crc_q, tx_crc_d, rx_crc_q, rx_crc_d;

  logic tick, lead, trail, is_last, sample, shift, frame_end;
  logic crc_clr, crc_upd, start_data, start_crc, launch;
  logic [BW-1:0] last_idx;
  logic [W-1:0]  load_word;

  spi_crc_tick #(.HALF_CYC(HALF_CYC)) i_tick (
    .clk (clk), .rst (rst), .run (state == SEQ_RUN), .tick (tick)
  );

  spi_crc_unit #(.W(W), .NW(NW)) i_tx_crc (
    .clk (clk), .rst (rst), .clr (crc_clr), .en (crc_upd), .wide (cfg_wide),
    .din (tx_sh[W-1]), .poly (crc_poly), .crc_q (tx_crc_q), .crc_d (tx_crc_d)
  );

  spi_crc_unit #(.W(W), .NW(NW)) i_rx_crc (
    .clk (clk), .rst (rst), .clr (crc_clr), .en (crc_upd), .wide (cfg_wide),
    .din (miso), .poly (crc_poly), .crc_q (rx_crc_q), .crc_d (rx_crc_d)
  );

  always_comb begin
    lead       = tick && !half_q;
    trail      = tick && half_q;
    last_idx   = cfg_wide ? BW'(W - 1) : BW'(NW - 1);
    is_last    = (bit_idx == last_idx);
    sample     = cfg_cpha ? trail : lead;
    shift      = cfg_cpha ? (lead && bit_idx != '0) : (trail && !is_last);
    frame_end  = trail && is_last;
    rx_nxt     = sample ? {rx_sh[W-2:0], miso} : rx_sh;
    crc_clr    = crc_en && !crc_en_q;
    crc_upd    = sample && crc_en && !crc_frame;
    start_data = tx_full;
    start_crc  = !tx_full && crc_next_q && !(frame_end && crc_frame);
    launch     = ((state == SEQ_IDLE) || frame_end) && (start_data || start_crc);
    load_word  = left_just(start_data ? tx_buf : tx_crc_d, cfg_wide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      half_q     <= 1'b0;
      bit_idx    <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      tx_buf     <= '0;
      tx_full    <= 1'b0;
      crc_frame  <= 1'b0;
      crc_next_q <= 1'b0;
      crc_err_q  <= 1'b0;
      crc_en_q   <= 1'b0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      busy_q     <= 1'b0;
      sck_q      <= cfg_cpol;
    end else begin
      crc_en_q <= crc_en;

      if (launch && start_data)  tx_full <= 1'b0;
      else if (tx_wr && !tx_full) begin
        tx_buf  <= tx_data;
        tx_full <= 1'b1;
      end

      if (crc_next_set)                 crc_next_q <= 1'b1;
      else if (frame_end && crc_frame)  crc_next_q <= 1'b0;

      if (frame_end && crc_frame && (rx_nxt != rx_crc_q)) crc_err_q <= 1'b1;
      else if (crc_err_clr)                                crc_err_q <= 1'b0;

      rx_valid_q <= frame_end;
      if (frame_end) rx_data_q <= rx_nxt;

      rx_sh <= launch ? '0 : rx_nxt;

      if (launch)     tx_sh <= load_word;
      else if (shift) tx_sh <= {tx_sh[W-2:0], 1'b0};

      if (launch)         state <= SEQ_RUN;
      else if (frame_end) state <= SEQ_IDLE;

      if (launch)    half_q <= 1'b0;
      else if (tick) half_q <= !half_q;

      if (launch)     bit_idx <= '0;
      else if (trail) bit_idx <= bit_idx + BW'(1);

      if (launch)         crc_frame <= !start_data;
      else if (frame_end) crc_frame <= 1'b0;

      if (lead)                              sck_q <= !cfg_cpol;
      else if (trail || state == SEQ_IDLE)   sck_q <= cfg_cpol;

      busy_q <= launch || (state == SEQ_RUN && !frame_end);
    end
  end

  assign tx_empty = !tx_full;
  assign crc_next = crc_next_q;
  assign rx_data  = rx_data_q;
  assign rx_valid = rx_valid_q;
  assign crc_err  = crc_err_q;
  assign err_irq  = crc_err_q && err_ie;
  assign busy     = busy_q;
  assign sck      = sck_q;
  assign mosi     = tx_sh[W-1];
endmodule

// File: rtl/spi_crc_master_chk.sv
module spi_crc_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_cpol,
  input logic        sck,
  input logic        busy,
  input logic        rx_valid,
  input logic        crc_err,
  input logic        crc_err_clr,
  input logic        crc_next,
  input logic        crc_frame,
  input logic        crc_clr,
  input logic [15:0] tx_crc_q,
  input logic [15:0] rx_crc_q
);
  // R8
  crc_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(crc_err) && !$past(crc_err_clr)) |-> crc_err);

  // R9
  crc_next_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(crc_next) |-> $past(busy));

  // R2
  sck_idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (sck == $past(cfg_cpol)));

  // R11
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(busy));

  // R7
  crc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(crc_frame) && !$past(crc_clr)) |-> ($stable(tx_crc_q) && $stable(rx_crc_q)));
endmodule

bind spi_crc_master spi_crc_master_chk i_chk (.*);

// File: tb/test_spi_crc_master.sv
`timescale 1ns/1ps
module test_spi_crc_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b1;
  logic [15:0] crc_poly = 16'h1021;
  logic        crc_en = 1'b0, err_ie = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_wr = 1'b0, crc_next_set = 1'b0, crc_err_clr = 1'b0;
  logic        inject = 1'b0;
  logic        tx_empty, crc_next, rx_valid, crc_err, err_irq, busy, sck, mosi, miso;
  logic [15:0] rx_data;

  always #2.5 clk = ~clk;
  assign miso = mosi ^ inject;

  spi_crc_master #(.HALF_CYC(2)) i_spi_crc_master (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide),
    .crc_poly(crc_poly), .crc_en(crc_en), .err_ie(err_ie), .tx_data(tx_data), .tx_wr(tx_wr),
    .tx_empty(tx_empty), .crc_next_set(crc_next_set), .crc_next(crc_next), .rx_data(rx_data),
    .rx_valid(rx_valid), .crc_err(crc_err), .crc_err_clr(crc_err_clr), .err_irq(err_irq),
    .busy(busy), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] mcrc = '0;
  logic [15:0] e_w;
  string       e_t;
  int          toggles = 0, busy_falls = 0;
  logic        sck_prev = 1'b0, busy_prev = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b,
                                           input logic wide, input logic [15:0] p);
    logic fb;
    logic [7:0] c8;
    if (wide) begin
      fb = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (fb ? p : 16'h0);
    end
    fb = c[7] ^ b;
    c8 = {c[6:0], 1'b0} ^ (fb ? p[7:0] : 8'h0);
    return {8'h00, c8};
  endfunction

  function automatic logic [15:0] wmask();
    return cfg_wide ? 16'hFFFF : 16'h00FF;
  endfunction

  // monitor: scoreboard pop and line statistics
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R12", "unexpected frame", rx_data, 16'h0);
        else begin
          e_w = exp_q.pop_front();
          e_t = tag_q.pop_front();
          check(rx_data == e_w, e_t, "received word", rx_data, e_w);
        end
      end
      if ((busy || busy_prev) && sck != sck_prev) toggles++;
      if (busy_prev && !busy) busy_falls++;
    end
    sck_prev  = sck;
    busy_prev = busy;
  end

  task automatic send(input logic [15:0] w, input string tag);
    while (!tx_empty) @(negedge clk);
    tx_data = w;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
    if (crc_en)
      for (int i = (cfg_wide ? 15 : 7); i >= 0; i--) mcrc = crc_step(mcrc, w[i], cfg_wide, crc_poly);
    exp_q.push_back(w & wmask());
    tag_q.push_back(tag);
  endtask

  task automatic req_crc(input bit corrupt, input string tag);
    crc_next_set = 1'b1;
    @(negedge clk);
    crc_next_set = 1'b0;
    check(crc_next == 1'b1, "R9", "crc_next after request", {15'h0, crc_next}, 16'h1);
    exp_q.push_back((corrupt ? ~mcrc : mcrc) & wmask());
    tag_q.push_back(tag);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy || !tx_empty || crc_next) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic wide);
    cfg_cpol = pol;
    cfg_cpha = pha;
    cfg_wide = wide;
    crc_poly = wide ? 16'h1021 : 16'h0007;
    crc_en   = 1'b0;
    @(negedge clk);
    crc_en   = 1'b1;
    mcrc     = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: got still running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0,     "R1", "busy",     {15'h0, busy},     16'h0);
    check(tx_empty == 1'b1, "R1", "tx_empty", {15'h0, tx_empty}, 16'h1);
    check(crc_err == 1'b0,  "R1", "crc_err",  {15'h0, crc_err},  16'h0);
    check(crc_next == 1'b0, "R1", "crc_next", {15'h0, crc_next}, 16'h0);
    check(err_irq == 1'b0,  "R1", "err_irq",  {15'h0, err_irq},  16'h0);
    check(sck == cfg_cpol,  "R1", "sck",      {15'h0, sck},      {15'h0, cfg_cpol});

    // R3 / R4 / R6 / R11 / R2: all four clock modes at both frame lengths, loopback
    for (int m = 0; m < 8; m++) begin
      set_mode(m[0], m[1], m[2]);
      toggles    = 0;
      busy_falls = 0;
      send(16'hA5C3 ^ 16'(m * 16'h1357), "R3");
      send(16'h3C96 + 16'(m), "R6");
      req_crc(1'b0, "R4");
      wait_idle();
      check(crc_err == 1'b0, "R8", "no error on loopback", {15'h0, crc_err}, 16'h0);
      check(crc_next == 1'b0, "R9", "auto clear", {15'h0, crc_next}, 16'h0);
      check(sck == cfg_cpol, "R2", "idle sck", {15'h0, sck}, {15'h0, cfg_cpol});
      check(toggles == (m[2] ? 96 : 48), "R2", "sck transitions", 16'(toggles), m[2] ? 16'd96 : 16'd48);
      check(busy_falls == 1, "R11", "busy falls once", 16'(busy_falls), 16'd1);
    end

    // R5: rising crc_en clears both CRCs
    set_mode(1'b0, 1'b1, 1'b1);
    send(16'h1234, "R3");
    wait_idle();
    crc_en = 1'b0;
    @(negedge clk);
    crc_en = 1'b1;
    mcrc   = '0;
    @(negedge clk);
    send(16'hBEEF, "R3");
    req_crc(1'b0, "R5");
    wait_idle();
    check(crc_err == 1'b0, "R5", "clear applied to both", {15'h0, crc_err}, 16'h0);

    // R7 repeat request, R8 corruption, R10 interrupt
    set_mode(1'b0, 1'b0, 1'b1);
    send(16'h0F0F, "R3");
    send(16'h8001, "R3");
    req_crc(1'b0, "R4");
    wait_idle();
    req_crc(1'b0, "R7");
    wait_idle();
    check(crc_err == 1'b0, "R7", "repeat crc matches", {15'h0, crc_err}, 16'h0);
    inject = 1'b1;
    req_crc(1'b1, "R8");
    wait_idle();
    inject = 1'b0;
    check(crc_err == 1'b1, "R8", "mismatch flagged", {15'h0, crc_err}, 16'h1);
    check(err_irq == 1'b0, "R10", "irq masked", {15'h0, err_irq}, 16'h0);
    err_ie = 1'b1;
    @(negedge clk);
    check(err_irq == 1'b1, "R10", "irq raised", {15'h0, err_irq}, 16'h1);
    send(16'h5555, "R3");
    req_crc(1'b0, "R4");
    wait_idle();
    check(crc_err == 1'b1, "R8", "flag sticky", {15'h0, crc_err}, 16'h1);
    crc_err_clr = 1'b1;
    @(negedge clk);
    crc_err_clr = 1'b0;
    @(negedge clk);
    check(crc_err == 1'b0, "R8", "flag cleared", {15'h0, crc_err}, 16'h0);
    check(err_irq == 1'b0, "R10", "irq follows clear", {15'h0, err_irq}, 16'h0);

    // R12: write while buffer full is dropped
    set_mode(1'b1, 1'b0, 1'b0);
    send(16'h00A1, "R12");
    repeat (3) @(negedge clk);
    tx_data = 16'h00B2;
    tx_wr   = 1'b1;
    @(negedge clk);
    exp_q.push_back(16'h00B2);
    tag_q.push_back("R12");
    tx_data = 16'h00C3;
    @(negedge clk);
    tx_wr   = 1'b0;
    check(tx_empty == 1'b0, "R12", "buffer held", {15'h0, tx_empty}, 16'h0);
    wait_idle();
    check(exp_q.size() == 0, "R12", "pending expectations", 16'(exp_q.size()), 16'h0);

    summary();
    $finish;
  end
endmodule